// File: doc/BRIEF.md
# Multi-Size Translation Lookaside Buffer

This block caches virtual-to-physical translations shared by instruction and data fetches. Sixteen fully associative entries each describe one page. A page is one of four sizes: 1 MB, 64 KB, 4 KB or 1 KB. A lookup compares only the address bits above the page boundary of each entry. A hit returns the physical address, the cacheable and bufferable attributes, and a verdict from a domain and access-permission check.

A lookup that finds no entry stalls the requester and raises a walk request toward an external page-table walker. The walker's result comes back on a fill port and is written into a round-robin victim slot. Slots below a lockdown base are never chosen as victims. A maintenance port clears every unlocked entry or only the entries that cover a given address.

Top module: `xlate_cache`

## Requirements
- R1: On a hit, `lk_pa` keeps the physical base bits above the page boundary and takes the lookup address bits below it. The boundary is bit 20 for size code 0 (1 MB), bit 16 for code 1 (64 KB), bit 12 for code 2 (4 KB) and bit 10 for code 3 (1 KB).
- R2: An entry matches only addresses within its own page. An address one page beyond it gives `lk_stall` and no hit.
- R3: Each entry carries four 2-bit permission fields, with field k at `ap[2k+1:2k]`. A 64 KB page selects the field with address bits [15:14] and a 4 KB page with bits [11:10]. 1 MB and 1 KB pages always use field 0.
- R4: Permission codes (for client domains) are as follows. 00 faults every access. 01 allows only privileged accesses. 10 allows privileged accesses and user reads, and faults user writes. 11 allows everything.
- R5: The entry's 4-bit domain d selects `dom_ctl[2d+1:2d]`. Code 11 (manager) hits without a permission check. Code 01 (client) applies R4. Codes 00 and 10 always fault.
- R6: On a hit, `lk_cach` and `lk_bufa` equal the attribute bits written with that entry.
- R7: A miss raises `lk_stall` in the same cycle. On the next clock `walk_req` rises and `walk_va` holds the missed address. Both stay unchanged until a fill, and `walk_req` drops on the clock that takes the fill.
- R8: Fills go to a round-robin pointer that starts at slot 0 after reset and advances by one per fill, wrapping after slot 15. The 17th fill after reset therefore replaces the first.
- R9: Slots numbered below `lock_base` are never written by a fill. When the pointer is below `lock_base`, the fill goes to slot `lock_base`.
- R10: `inv_all` clears every entry at or above `lock_base`. Locked entries keep hitting.
- R11: `inv_vtag` with `inv_va_en` clears each entry, locked or not, whose page contains that address, judged by the entry's own size. Other entries are kept.
- R12: A lookup matching more than one entry asserts `lk_fault` and not `lk_hit`. Exactly one of hit, fault and stall is set on each valid lookup.
- R13: After reset, no entry is valid and `walk_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_va | input | 32 | Lookup virtual address |
| lk_priv | input | 1 | Lookup made in privileged mode |
| lk_write | input | 1 | Lookup is a write |
| lk_hit | output | 1 | Translation found and access allowed |
| lk_fault | output | 1 | Access denied or multiple matches |
| lk_stall | output | 1 | No entry matches; requester must hold |
| lk_pa | output | 32 | Translated physical address |
| lk_cach | output | 1 | Cacheable attribute of the hit |
| lk_bufa | output | 1 | Bufferable attribute of the hit |
| walk_req | output | 1 | Page-table walk requested |
| walk_va | output | 32 | Address to be walked |
| fill_valid | input | 1 | Write a new entry |
| fill_vtag | input | 22 | Virtual address bits 31:10 of the new page |
| fill_pbase | input | 22 | Physical address bits 31:10 of the new page |
| fill_size | input | 2 | Page size code (see R1) |
| fill_ap | input | 8 | Four 2-bit permission fields |
| fill_dom | input | 4 | Domain number |
| fill_cach | input | 1 | Cacheable attribute |
| fill_bufa | input | 1 | Bufferable attribute |
| dom_ctl | input | 32 | Sixteen 2-bit domain access codes |
| inv_all | input | 1 | Clear all unlocked entries |
| inv_va_en | input | 1 | Clear entries covering `inv_vtag` |
| inv_vtag | input | 22 | Virtual address bits 31:10 to invalidate |
| lock_base | input | 4 | Slots below this number are locked |

## Verification
A wrong tag mask or size code shows up at the ports on the same cycle. A lookup that should hit stalls, or `lk_pa` carries the wrong offset bits. A victim pointer that skips, repeats or enters the locked range stays hidden until enough fills have been made. It then shows as an early miss on an entry that should have survived, or as a surviving entry that should have been replaced. The bench therefore counts fills exactly and probes both sides of each replacement. A stale valid bit after maintenance shows as a hit on the very next lookup.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int VA_W     = 32;
  localparam int OFF_W    = 10;            // smallest page offset
  localparam int TAG_W    = VA_W - OFF_W;
  localparam int SECT_SH  = 20;
  localparam int LARGE_SH = 16;
  localparam int SMALL_SH = 12;
  localparam int DOM_W    = 4;
  localparam int DCTL_W   = 2 << DOM_W;
  localparam int AP_W     = 8;

  typedef enum logic [1:0] {
    PG_SECT  = 2'd0,
    PG_LARGE = 2'd1,
    PG_SMALL = 2'd2,
    PG_TINY  = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] vtag;
    logic [TAG_W-1:0] pbase;
    pg_size_e         size;
    logic [AP_W-1:0]  ap;
    logic [DOM_W-1:0] dom;
    logic             cach;
    logic             bufa;
  } tlb_ent_t;

  // Tag bits that take part in the compare for a given page size.
  function automatic logic [TAG_W-1:0] cmp_mask(pg_size_e s);
    logic [TAG_W-1:0] m;
    m = '1;
    case (s)
      PG_SECT:  m = m << (SECT_SH - OFF_W);
      PG_LARGE: m = m << (LARGE_SH - OFF_W);
      PG_SMALL: m = m << (SMALL_SH - OFF_W);
      default:  m = '1;
    endcase
    return m;
  endfunction

  // Quarter-page index: the two address bits just under the page boundary.
  function automatic logic [1:0] quarter_sel(pg_size_e s, logic [TAG_W-1:0] t);
    logic [1:0] q;
    case (s)
      PG_LARGE: q = t[LARGE_SH-OFF_W-2 +: 2];
      PG_SMALL: q = t[SMALL_SH-OFF_W-2 +: 2];
      default:  q = 2'd0;
    endcase
    return q;
  endfunction
endpackage

// File: rtl/xlt_entry_match.sv
module xlt_entry_match
  import xlt_pkg::*;
(
  input  logic             valid,
  input  logic [TAG_W-1:0] vtag,
  input  pg_size_e         size,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic [TAG_W-1:0] inv_tag,
  output logic             lk_match,
  output logic             inv_match
);
  logic [TAG_W-1:0] mask;

  always_comb begin
    mask      = cmp_mask(size);
    lk_match  = valid && (((vtag ^ lk_tag) & mask) == '0);
    inv_match = valid && (((vtag ^ inv_tag) & mask) == '0);
  end
endmodule

// File: rtl/xlt_perm_check.sv
module xlt_perm_check
  import xlt_pkg::*;
(
  input  logic [1:0]        ap_fld,
  input  logic [DOM_W-1:0]  dom,
  input  logic [DCTL_W-1:0] dom_ctl,
  input  logic              priv,
  input  logic              wr,
  output logic              fault
);
  logic [1:0] dcode;

  always_comb begin
    dcode = dom_ctl[{dom, 1'b0} +: 2];
    case (dcode)
      2'b11: fault = 1'b0;                 // manager: no permission check
      2'b01: begin                         // client: apply the permission field
        case (ap_fld)
          2'b00:   fault = 1'b1;
          2'b01:   fault = !priv;
          2'b10:   fault = !priv && wr;
          default: fault = 1'b0;
        endcase
      end
      default: fault = 1'b1;               // no access / reserved
    endcase
  end
endmodule

// File: rtl/xlt_victim.sv
module xlt_victim #(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] lock_base,
  output logic [IDX_W-1:0] victim
);
  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    victim = (ptr_q < lock_base) ? lock_base : ptr_q;
    ptr_d  = ptr_q;
    if (fill_en) ptr_d = victim + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (fill_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlt_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic              lk_priv,
  input  logic              lk_write,
  output logic              lk_hit,
  output logic              lk_fault,
  output logic              lk_stall,
  output logic [VA_W-1:0]   lk_pa,
  output logic              lk_cach,
  output logic              lk_bufa,
  output logic              walk_req,
  output logic [VA_W-1:0]   walk_va,
  input  logic              fill_valid,
  input  logic [TAG_W-1:0]  fill_vtag,
  input  logic [TAG_W-1:0]  fill_pbase,
  input  logic [1:0]        fill_size,
  input  logic [AP_W-1:0]   fill_ap,
  input  logic [DOM_W-1:0]  fill_dom,
  input  logic              fill_cach,
  input  logic              fill_bufa,
  input  logic [DCTL_W-1:0] dom_ctl,
  input  logic              inv_all,
  input  logic              inv_va_en,
  input  logic [TAG_W-1:0]  inv_vtag,
  input  logic [IDX_W-1:0]  lock_base
);
  tlb_ent_t         ent_q [N_ENT];
  tlb_ent_t         ent_d [N_ENT];
  tlb_ent_t         new_ent;
  logic [N_ENT-1:0] hits, inv_hits;
  logic [IDX_W-1:0] victim;
  logic [TAG_W-1:0] lk_tag;

  // selected-entry fields
  logic [TAG_W-1:0] s_pbase;
  pg_size_e         s_size;
  logic [AP_W-1:0]  s_ap;
  logic [DOM_W-1:0] s_dom;
  logic             s_cach, s_bufa;
  logic             any_hit, multi_hit, perm_fault;
  logic [1:0]       s_quarter, s_apfld;
  logic [TAG_W-1:0] s_mask;

  logic             wait_q, wait_d;
  logic [VA_W-1:0]  wva_q, wva_d;

  assign lk_tag = lk_va[VA_W-1:OFF_W];

  always_comb begin
    new_ent       = '0;
    new_ent.valid = 1'b1;
    new_ent.vtag  = fill_vtag;
    new_ent.pbase = fill_pbase;
    new_ent.size  = pg_size_e'(fill_size);
    new_ent.ap    = fill_ap;
    new_ent.dom   = fill_dom;
    new_ent.cach  = fill_cach;
    new_ent.bufa  = fill_bufa;
  end

  xlt_victim #(.N_ENT(N_ENT)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_en   (fill_valid),
    .lock_base (lock_base),
    .victim    (victim)
  );

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    localparam logic [IDX_W-1:0] IDX = IDX_W'(i);

    xlt_entry_match u_match (
      .valid     (ent_q[i].valid),
      .vtag      (ent_q[i].vtag),
      .size      (ent_q[i].size),
      .lk_tag    (lk_tag),
      .inv_tag   (inv_vtag),
      .lk_match  (hits[i]),
      .inv_match (inv_hits[i])
    );

    always_comb begin
      ent_d[i] = ent_q[i];
      if ((inv_all && (IDX >= lock_base)) || (inv_va_en && inv_hits[i]))
        ent_d[i].valid = 1'b0;
      if (fill_valid && (victim == IDX))
        ent_d[i] = new_ent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent_q[i] <= '0;
      else if (fill_valid || inv_all || inv_va_en)
        ent_q[i] <= ent_d[i];
    end

    // Locked slots are untouched by fills and by invalidate-all.
    p_lock_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!inv_va_en && (IDX < lock_base)) |=> $stable(ent_q[i]));
    // Unlocked slots are empty after invalidate-all.
    p_inv_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_all && !fill_valid && (IDX >= lock_base)) |=> !ent_q[i].valid);
  end

  // one-hot OR mux of the matching entry's payload
  always_comb begin
    s_pbase = '0;
    s_ap    = '0;
    s_dom   = '0;
    s_cach  = 1'b0;
    s_bufa  = 1'b0;
    s_size  = PG_SECT;
    for (int i = 0; i < N_ENT; i++) begin
      if (hits[i]) begin
        s_pbase = s_pbase | ent_q[i].pbase;
        s_ap    = s_ap    | ent_q[i].ap;
        s_dom   = s_dom   | ent_q[i].dom;
        s_cach  = s_cach  | ent_q[i].cach;
        s_bufa  = s_bufa  | ent_q[i].bufa;
        s_size  = pg_size_e'(s_size | ent_q[i].size);
      end
    end
  end

  always_comb begin
    any_hit   = |hits;
    multi_hit = |(hits & (hits - 1'b1));
    s_quarter = quarter_sel(s_size, lk_tag);
    s_apfld   = s_ap[{s_quarter, 1'b0} +: 2];
    s_mask    = cmp_mask(s_size);
  end

  xlt_perm_check u_perm (
    .ap_fld  (s_apfld),
    .dom     (s_dom),
    .dom_ctl (dom_ctl),
    .priv    (lk_priv),
    .wr      (lk_write),
    .fault   (perm_fault)
  );

  always_comb begin
    lk_stall = lk_valid && !any_hit;
    lk_fault = lk_valid && any_hit && (multi_hit || perm_fault);
    lk_hit   = lk_valid && any_hit && !multi_hit && !perm_fault;
    lk_pa    = {(s_pbase & s_mask) | (lk_tag & ~s_mask), lk_va[OFF_W-1:0]};
    lk_cach  = lk_hit && s_cach;
    lk_bufa  = lk_hit && s_bufa;
  end

  // walk request: raised the cycle after a miss, held until a fill
  always_comb begin
    wait_d = wait_q;
    wva_d  = wva_q;
    if (wait_q) begin
      if (fill_valid) wait_d = 1'b0;
    end else if (lk_stall && !fill_valid) begin
      wait_d = 1'b1;
      wva_d  = lk_va;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  wait_q <= 1'b0;
    else if (wait_q != wait_d)   wait_q <= wait_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  wva_q <= '0;
    else if (!wait_q && wait_d)  wva_q <= wva_d;
  end

  assign walk_req = wait_q;
  assign walk_va  = wva_q;

  p_miss_walk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_stall && !walk_req && !fill_valid) |=> (walk_req && walk_va == $past(lk_va)));
  p_walk_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !fill_valid) |=> (walk_req && $stable(walk_va)));
  p_walk_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !walk_req);
  p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot({lk_hit, lk_fault, lk_stall}));
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_fault || lk_stall || lk_cach || lk_bufa));
endmodule

// File: tb/tb_xlate_cache.sv
module tb_xlate_cache;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_priv, lk_write;
  logic [31:0] lk_va;
  logic        lk_hit, lk_fault, lk_stall, lk_cach, lk_bufa, walk_req;
  logic [31:0] lk_pa, walk_va;
  logic        fill_valid, fill_cach, fill_bufa;
  logic [21:0] fill_vtag, fill_pbase, inv_vtag;
  logic [1:0]  fill_size;
  logic [7:0]  fill_ap;
  logic [3:0]  fill_dom;
  logic [31:0] dom_ctl;
  logic        inv_all, inv_va_en;
  logic [3:0]  lock_base;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  xlate_cache dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va),
    .lk_priv(lk_priv), .lk_write(lk_write), .lk_hit(lk_hit),
    .lk_fault(lk_fault), .lk_stall(lk_stall), .lk_pa(lk_pa),
    .lk_cach(lk_cach), .lk_bufa(lk_bufa), .walk_req(walk_req),
    .walk_va(walk_va), .fill_valid(fill_valid), .fill_vtag(fill_vtag),
    .fill_pbase(fill_pbase), .fill_size(fill_size), .fill_ap(fill_ap),
    .fill_dom(fill_dom), .fill_cach(fill_cach), .fill_bufa(fill_bufa),
    .dom_ctl(dom_ctl), .inv_all(inv_all), .inv_va_en(inv_va_en),
    .inv_vtag(inv_vtag), .lock_base(lock_base)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    lk_valid = 0; lk_va = '0; lk_priv = 0; lk_write = 0;
    fill_valid = 0; fill_vtag = '0; fill_pbase = '0; fill_size = '0;
    fill_ap = '0; fill_dom = '0; fill_cach = 0; fill_bufa = 0;
    dom_ctl = 32'h5555_5555; inv_all = 0; inv_va_en = 0; inv_vtag = '0;
    lock_base = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                      input logic [7:0] ap, input logic [3:0] dm, input bit c, input bit b);
    @(negedge clk);
    fill_valid = 1; fill_vtag = va[31:10]; fill_pbase = pa[31:10];
    fill_size = sz; fill_ap = ap; fill_dom = dm; fill_cach = c; fill_bufa = b;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic probe(input logic [31:0] va, input bit pr, input bit wr);
    @(negedge clk);
    lk_valid = 1; lk_va = va; lk_priv = pr; lk_write = wr;
    #1;
  endtask

  task automatic exp_hit(input string req, input logic [31:0] va, input bit pr,
                         input bit wr, input logic [31:0] pa);
    probe(va, pr, wr);
    check(req, {lk_hit, lk_fault, lk_stall}, 3'b100);
    check(req, lk_pa, pa);
    #1 lk_valid = 0;
  endtask

  task automatic exp_fault(input string req, input logic [31:0] va, input bit pr, input bit wr);
    probe(va, pr, wr);
    check(req, {lk_hit, lk_fault, lk_stall}, 3'b010);
    #1 lk_valid = 0;
  endtask

  task automatic exp_miss(input string req, input logic [31:0] va);
    probe(va, 1'b1, 1'b0);
    check(req, {lk_hit, lk_fault, lk_stall}, 3'b001);
    #1 lk_valid = 0;
  endtask

  task automatic pulse_inv_all();
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
  endtask

  task automatic pulse_inv_va(input logic [31:0] va);
    @(negedge clk); inv_va_en = 1; inv_vtag = va[31:10];
    @(negedge clk); inv_va_en = 0;
  endtask

  task automatic t_reset();
    do_reset();
    #1 check("R13 walk_req after reset", walk_req, 1'b0);
    exp_miss("R13 empty after reset", 32'h0000_0000);
    exp_miss("R13 empty after reset", 32'h4000_0000);
  endtask

  task automatic t_sizes();
    do_reset();
    fill(32'h4000_0000, 32'h8000_0000, 2'd0, 8'hFF, 4'd0, 0, 0);
    fill(32'h5001_0000, 32'h9002_0000, 2'd1, 8'hFF, 4'd0, 0, 0);
    fill(32'h6000_3000, 32'hA000_5000, 2'd2, 8'hFF, 4'd0, 0, 0);
    fill(32'h7000_0400, 32'hB000_0800, 2'd3, 8'hFF, 4'd0, 0, 0);
    exp_hit("R1 section", 32'h400A_BCDE, 1, 0, 32'h800A_BCDE);
    exp_hit("R1 large",   32'h5001_F123, 1, 0, 32'h9002_F123);
    exp_hit("R1 small",   32'h6000_3ABC, 1, 0, 32'hA000_5ABC);
    exp_hit("R1 tiny",    32'h7000_07FF, 1, 0, 32'hB000_0BFF);
    exp_miss("R2 past section", 32'h4010_0000);
    exp_miss("R2 past large",   32'h5002_0000);
    exp_miss("R2 past small",   32'h6000_4000);
    exp_miss("R2 past tiny",    32'h7000_0800);
  endtask

  task automatic t_perm();
    do_reset();
    fill(32'h5001_0000, 32'h9002_0000, 2'd1, 8'b11_10_01_00, 4'd0, 0, 0);
    fill(32'h6000_3000, 32'hA000_5000, 2'd2, 8'b11_10_01_00, 4'd0, 0, 0);
    fill(32'h4000_0000, 32'h8000_0000, 2'd0, 8'b00_00_00_11, 4'd0, 0, 0);
    exp_fault("R3 R4 large q0 code 00", 32'h5001_0000, 1, 0);
    exp_fault("R3 R4 large q1 user",    32'h5001_4000, 0, 0);
    exp_hit("R3 R4 large q1 priv",      32'h5001_4000, 1, 1, 32'h9002_4000);
    exp_hit("R3 R4 large q2 user read", 32'h5001_8000, 0, 0, 32'h9002_8000);
    exp_fault("R3 R4 large q2 user write", 32'h5001_8000, 0, 1);
    exp_hit("R3 R4 large q3 user write",   32'h5001_C000, 0, 1, 32'h9002_C000);
    exp_fault("R3 small q1 user",       32'h6000_3400, 0, 0);
    exp_hit("R3 small q3 user write",   32'h6000_3C00, 0, 1, 32'hA000_5C00);
    exp_hit("R3 section uses field 0",  32'h4000_4000, 0, 1, 32'h8000_4000);
  endtask

  task automatic t_domain();
    do_reset();
    fill(32'h2000_0000, 32'h3000_0000, 2'd2, 8'h00, 4'd5, 0, 0);
    dom_ctl = 32'h5555_5555 | (32'd3 << 10);
    exp_hit("R5 manager bypass", 32'h2000_0010, 0, 1, 32'h3000_0010);
    dom_ctl = 32'h5555_5555;
    exp_fault("R5 client checks ap", 32'h2000_0010, 1, 0);
    dom_ctl = 32'h5555_5555 & ~(32'd3 << 10);
    exp_fault("R5 no access", 32'h2000_0010, 1, 0);
    dom_ctl = (32'h5555_5555 & ~(32'd3 << 10)) | (32'd2 << 10);
    exp_fault("R5 reserved code", 32'h2000_0010, 1, 0);
    dom_ctl = 32'h5555_5555;
  endtask

  task automatic t_attr();
    do_reset();
    fill(32'h1100_0000, 32'h2100_0000, 2'd2, 8'hFF, 4'd0, 1, 0);
    fill(32'h1100_1000, 32'h2100_1000, 2'd2, 8'hFF, 4'd0, 0, 1);
    probe(32'h1100_0004, 1, 0);
    check("R6 cacheable only", {lk_cach, lk_bufa}, 2'b10);
    #1 lk_valid = 0;
    probe(32'h1100_1004, 1, 0);
    check("R6 bufferable only", {lk_cach, lk_bufa}, 2'b01);
    #1 lk_valid = 0;
  endtask

  task automatic t_miss_walk();
    do_reset();
    @(negedge clk);
    lk_valid = 1; lk_va = 32'h1234_5678; lk_priv = 1; lk_write = 0;
    #1;
    check("R7 stall same cycle", {lk_stall, walk_req}, 2'b10);
    @(negedge clk); #1;
    check("R7 walk_req next cycle", walk_req, 1'b1);
    check("R7 walk_va", walk_va, 32'h1234_5678);
    repeat (3) @(negedge clk);
    #1 check("R7 walk held", {walk_req, lk_stall}, 2'b11);
    fill(32'h1234_5678, 32'h5600_0000, 2'd2, 8'hFF, 4'd0, 0, 0);
    #1;
    check("R7 walk drops after fill", walk_req, 1'b0);
    check("R7 lookup hits after fill", {lk_hit, lk_pa}, {1'b1, 32'h5600_0678});
    lk_valid = 0;
  endtask

  task automatic t_round_robin();
    do_reset();
    for (int k = 0; k < 17; k++)
      fill(32'h1000_0000 + k * 32'h1000, 32'h8000_0000 + k * 32'h1000, 2'd2, 8'hFF, 4'd0, 0, 0);
    exp_miss("R8 17th fill replaced slot 0", 32'h1000_0000);
    exp_hit("R8 slot 1 kept", 32'h1000_1000, 1, 0, 32'h8000_1000);
    exp_hit("R8 latest fill", 32'h1001_0000, 1, 0, 32'h8001_0000);
  endtask

  task automatic t_lock_inv();
    do_reset();
    fill(32'h3000_0000, 32'h9000_0000, 2'd2, 8'hFF, 4'd0, 0, 0);
    fill(32'h3000_1000, 32'h9000_1000, 2'd2, 8'hFF, 4'd0, 0, 0);
    @(negedge clk) lock_base = 4'd2;
    for (int k = 0; k < 15; k++)
      fill(32'h3100_0000 + k * 32'h1000, 32'hA000_0000 + k * 32'h1000, 2'd2, 8'hFF, 4'd0, 0, 0);
    exp_hit("R9 locked slot 0 kept", 32'h3000_0000, 1, 0, 32'h9000_0000);
    exp_hit("R9 locked slot 1 kept", 32'h3000_1000, 1, 0, 32'h9000_1000);
    exp_miss("R9 wrap lands on lock_base", 32'h3100_0000);
    exp_hit("R9 next unlocked kept", 32'h3100_1000, 1, 0, 32'hA000_1000);
    pulse_inv_all();
    exp_hit("R10 locked survives", 32'h3000_0000, 1, 0, 32'h9000_0000);
    exp_miss("R10 unlocked cleared", 32'h3100_1000);
    exp_miss("R10 unlocked cleared", 32'h3100_E000);
    pulse_inv_va(32'h3000_0000);
    exp_miss("R11 locked entry cleared by address", 32'h3000_0000);
    exp_hit("R11 neighbour kept", 32'h3000_1000, 1, 0, 32'h9000_1000);
    fill(32'h5001_0000, 32'h9002_0000, 2'd1, 8'hFF, 4'd0, 0, 0);
    fill(32'h6000_3000, 32'hA000_5000, 2'd2, 8'hFF, 4'd0, 0, 0);
    pulse_inv_va(32'h5001_C000);
    exp_miss("R11 large page cleared by inner address", 32'h5001_0000);
    pulse_inv_va(32'h6000_4000);
    exp_hit("R11 small page outside address kept", 32'h6000_3010, 1, 0, 32'hA000_5010);
  endtask

  task automatic t_multi();
    do_reset();
    fill(32'h4000_0000, 32'h8000_0000, 2'd0, 8'hFF, 4'd0, 0, 0);
    fill(32'h4000_5000, 32'hC000_0000, 2'd2, 8'hFF, 4'd0, 0, 0);
    exp_fault("R12 double match faults", 32'h4000_5004, 1, 0);
    exp_hit("R12 single match hits", 32'h4000_6000, 1, 0, 32'h8000_6000);
  endtask

  initial begin
    t_reset();
    t_sizes();
    t_perm();
    t_domain();
    t_attr();
    t_miss_walk();
    t_round_robin();
    t_lock_inv();
    t_multi();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule